// File: doc/BRIEF.md
# Windowed Viterbi Survivor Traceback

This block turns the per-stage survivor decisions of a Viterbi path metric unit into decoded data bits. Each clock edge is one trellis stage. At that edge the block takes one decision vector, with one bit per state, and the packed path metrics of that stage. A wrapping window counter divides the stage stream into windows of `WIN_LEN` stages. At the last stage of each window the block copies the buffered decisions into a traceback register chain. It also picks the start state, which is the state with the largest metric at that stage.

Over the next window the block walks backward one stage per clock and collects one decoded bit per step. When the next window closes, it presents the whole window on a parallel bit line in forward stage order, together with a one-cycle valid strobe. The first window after reset is used only as warm-up and gives no output.

The trellis shifts left: from state `s` with input bit `u`, the next state is `((s << 1) | u) mod 2^(K-1)`. The input bit of a state is therefore its LSB, and its predecessor is fixed by the MSB that was dropped.

Top module: `viterbi_traceback`

## Requirements
- R1: A window counter is cleared by reset and counts 0 to `WIN_LEN`-1, then wraps. `restart` is high exactly while the count equals `WIN_LEN`-1, so after c edges since reset release it is high when c mod `WIN_LEN` equals `WIN_LEN`-1.
- R2: Stages are numbered by clock edge since reset release, starting at 0. Window w holds stages w·`WIN_LEN` to w·`WIN_LEN`+`WIN_LEN`-1. Window 0 is warm-up only and produces no output.
- R3: `bit_valid` is a single-cycle pulse. For window w ≥ 1 it is high in the cycle after edge (w+2)·`WIN_LEN`-1 and at no other time.
- R4: The start state is chosen from the metrics presented with the last stage of the window. Each metric sits at `path_metrics[s*METRIC_W +: METRIC_W]` and is unsigned. The scan runs from state 0 upward with a running maximum that starts at 0. A state wins only with a strictly larger metric, so ties go to the lowest index and all-zero metrics give state 0.
- R5: Bit s of `dec_vec` is the survivor decision of state s. Each backward step outputs the LSB of the current state as the decoded bit. It then moves to the predecessor `{dec_vec_of_that_stage[state], state[K-2:1]}`.
- R6: `bit_line[i]` is the decoded bit of stage i of the window, with i = 0 the oldest stage. The value holds until the next pulse.
- R7: Reset clears `bit_line` and `bit_valid`. It also restarts warm-up, so no pulse appears before 3·`WIN_LEN` edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock, one trellis stage per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_vec | input | 2^(K-1) | Survivor decision bit per state for this stage |
| path_metrics | input | 2^(K-1)·METRIC_W | Unsigned path metric per state, state 0 in the low bits |
| restart | output | 1 | High during the last stage of each window |
| bit_line | output | WIN_LEN | Decoded bits of a window, oldest stage in bit 0 |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_line` |

## Verification
`restart` is combinational from the counter. After c edges it is due in the same cycle, and the bench compares it with c mod `WIN_LEN` at every falling edge. A window's decoded bits appear one full window after its own closing edge, that is after edge (w+2)·`WIN_LEN`-1. The bench therefore keeps a count of edges since reset and expects the strobe, together with the reference traceback of window w, only at the falling edge after that count. At every other falling edge it expects the strobe to be low. The metric patterns rotate among a clear winner, all zeros, a tie, and random values. With a clear winner, the decoded bits must also equal the bits that generated the path.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
   // number of trellis states for a constraint length
   function automatic int num_states(input int k);
      return 1 << (k - 1);
   endfunction

   // bits needed to hold the value n-1, at least one
   function automatic int cnt_bits(input int n);
      int b;
      b = 0;
      while ((1 << b) < n) b++;
      return (b < 1) ? 1 : b;
   endfunction
endpackage

// File: rtl/vtb_window_ctrl.sv
module vtb_window_ctrl #(
   parameter int WIN_LEN = 4
) (
   input  logic clk,
   input  logic rst,
   output logic restart,
   output logic primed
);
   localparam int CW = vtb_pkg::cnt_bits(WIN_LEN);
   localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

   logic [CW-1:0] cnt;

   assign restart = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         primed <= 1'b0;
      end else if (restart) begin
         cnt    <= '0;
         primed <= 1'b1;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/vtb_start_select.sv
module vtb_start_select #(
   parameter int NS = 4,
   parameter int MW = 8
) (
   input  logic [NS*MW-1:0]     metrics,
   output logic [$clog2(NS)-1:0] best_state
);
   localparam int SB = $clog2(NS);

   logic [MW-1:0] best_val;

   always_comb begin
      best_val   = '0;
      best_state = '0;
      for (int i = 0; i < NS; i++) begin
         if (metrics[i*MW +: MW] > best_val) begin
            best_val   = metrics[i*MW +: MW];
            best_state = SB'(i);
         end
      end
   end
endmodule

// File: rtl/vtb_decision_store.sv
module vtb_decision_store #(
   parameter int NS      = 4,
   parameter int WIN_LEN = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  logic [NS-1:0] dec_in,
   output logic [NS-1:0] tb_head
);
   localparam int DL = WIN_LEN - 1;

   logic [NS-1:0] dly [DL];
   logic [NS-1:0] tb  [WIN_LEN];

   // delay line: dly[0] holds the newest stored stage
   always_ff @(posedge clk) begin
      if (rst) dly[0] <= '0;
      else     dly[0] <= dec_in;
   end

   generate
      for (genvar i = 1; i < DL; i++) begin : g_dly
         always_ff @(posedge clk) begin
            if (rst) dly[i] <= '0;
            else     dly[i] <= dly[i-1];
         end
      end
   endgenerate

   // traceback chain: parallel load on restart, else shift toward head
   always_ff @(posedge clk) begin
      if (rst)          tb[0] <= '0;
      else if (restart) tb[0] <= dec_in;
      else              tb[0] <= tb[1];
   end

   generate
      for (genvar i = 1; i < WIN_LEN; i++) begin : g_tb
         if (i == WIN_LEN - 1) begin : g_tail
            always_ff @(posedge clk) begin
               if (rst)          tb[i] <= '0;
               else if (restart) tb[i] <= dly[i-1];
               else              tb[i] <= '0;
            end
         end else begin : g_mid
            always_ff @(posedge clk) begin
               if (rst)          tb[i] <= '0;
               else if (restart) tb[i] <= dly[i-1];
               else              tb[i] <= tb[i+1];
            end
         end
      end
   endgenerate

   assign tb_head = tb[0];
endmodule

// File: rtl/vtb_walk.sv
module vtb_walk #(
   parameter int NS      = 4,
   parameter int WIN_LEN = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  restart,
   input  logic                  primed,
   input  logic [$clog2(NS)-1:0] start_state,
   input  logic [NS-1:0]         tb_head,
   output logic [WIN_LEN-1:0]    bits,
   output logic                  valid
);
   localparam int SB = $clog2(NS);

   logic [SB-1:0]      cur;
   logic [WIN_LEN-1:0] acc;
   logic               busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur   <= '0;
         acc   <= '0;
         busy  <= 1'b0;
         bits  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (restart) begin
            if (busy) begin
               bits  <= {acc[WIN_LEN-2:0], cur[0]};
               valid <= 1'b1;
            end
            cur  <= start_state;
            acc  <= '0;
            busy <= primed;
         end else if (busy) begin
            acc <= {acc[WIN_LEN-2:0], cur[0]};
            cur <= {tb_head[cur], cur[SB-1:1]};
         end
      end
   end
endmodule

// File: rtl/viterbi_traceback.sv
module viterbi_traceback #(
   parameter int CONSTR_LEN = 3,
   parameter int WIN_LEN    = 4,
   parameter int METRIC_W   = 8
) (
   input  logic                                      clk,
   input  logic                                      rst,
   input  logic [(1<<(CONSTR_LEN-1))-1:0]            dec_vec,
   input  logic [(1<<(CONSTR_LEN-1))*METRIC_W-1:0]   path_metrics,
   output logic                                      restart,
   output logic [WIN_LEN-1:0]                        bit_line,
   output logic                                      bit_valid
);
   localparam int NS = vtb_pkg::num_states(CONSTR_LEN);
   localparam int SB = $clog2(NS);

   generate
      if (CONSTR_LEN < 3) begin : g_bad_k
         $error("CONSTR_LEN must be at least 3");
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (METRIC_W < 1) begin : g_bad_mw
         $error("METRIC_W must be positive");
      end
   endgenerate

   logic          primed;
   logic [SB-1:0] start_state;
   logic [NS-1:0] tb_head;

   vtb_window_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
      .clk(clk), .rst(rst), .restart(restart), .primed(primed)
   );

   vtb_start_select #(.NS(NS), .MW(METRIC_W)) u_sel (
      .metrics(path_metrics), .best_state(start_state)
   );

   vtb_decision_store #(.NS(NS), .WIN_LEN(WIN_LEN)) u_store (
      .clk(clk), .rst(rst), .restart(restart), .dec_in(dec_vec),
      .tb_head(tb_head)
   );

   vtb_walk #(.NS(NS), .WIN_LEN(WIN_LEN)) u_walk (
      .clk(clk), .rst(rst), .restart(restart), .primed(primed),
      .start_state(start_state), .tb_head(tb_head),
      .bits(bit_line), .valid(bit_valid)
   );
endmodule

// File: rtl/viterbi_traceback_chk.sv
module viterbi_traceback_chk #(
   parameter int WIN_LEN = 4
) (
   input logic clk,
   input logic rst,
   input logic restart,
   input logic bit_valid
);
   localparam int GW = vtb_pkg::cnt_bits(WIN_LEN + 1) + 1;

   logic [GW-1:0] gap;
   logic [1:0]    seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= '0;
         seen <= '0;
      end else begin
         gap <= restart ? '0 : gap + GW'(1);
         if (restart && seen != 2'd3) seen <= seen + 2'd1;
      end
   end

   // R1
   restart_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      restart |-> (gap == GW'(WIN_LEN - 1) || seen == 2'd0));

   // R1
   restart_single_chk: assert property (@(posedge clk) disable iff (rst)
      restart |=> !restart);

   // R3
   valid_after_restart_chk: assert property (@(posedge clk) disable iff (rst)
      bit_valid |-> $past(restart));

   // R3
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      bit_valid |=> !bit_valid);

   // R2
   no_warmup_output_chk: assert property (@(posedge clk) disable iff (rst)
      bit_valid |-> seen >= 2'd2);

   // R7
   reset_clears_valid_chk: assert property (@(posedge clk)
      rst |=> !bit_valid);
endmodule

bind viterbi_traceback viterbi_traceback_chk #(.WIN_LEN(WIN_LEN)) u_chk (
   .clk(clk), .rst(rst), .restart(restart), .bit_valid(bit_valid)
);

// File: tb/tb_viterbi_traceback.sv
module tb_viterbi_traceback;
   localparam int K   = 3;
   localparam int B   = 4;
   localparam int MW  = 4;
   localparam int NS  = 1 << (K - 1);
   localparam int SB  = K - 1;
   localparam int NST = 200;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NS-1:0]     dec_vec = '0;
   logic [NS*MW-1:0]  path_metrics = '0;
   logic              restart;
   logic [B-1:0]      bit_line;
   logic              bit_valid;

   int n_chk = 0, n_fail = 0;
   int c;
   logic [NS-1:0] dec_hist [NST];
   int            met      [NST][NS];
   logic          u_hist   [NST];

   always #10 clk = ~clk;

   viterbi_traceback #(.CONSTR_LEN(K), .WIN_LEN(B), .METRIC_W(MW)) dut (
      .clk(clk), .rst(rst), .dec_vec(dec_vec), .path_metrics(path_metrics),
      .restart(restart), .bit_line(bit_line), .bit_valid(bit_valid)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, c);
      end
   endtask

   // reference traceback for window w (R4, R5, R6)
   function automatic logic [B-1:0] model(input int w);
      logic [B-1:0]  r;
      logic [SB-1:0] st;
      int            best, last;
      last = w*B + B - 1;
      best = 0; st = '0;
      for (int s = 0; s < NS; s++)
         if (met[last][s] > best) begin best = met[last][s]; st = SB'(s); end
      for (int j = B - 1; j >= 0; j--) begin
         r[j] = st[0];
         st = {dec_hist[w*B + j][st], st[SB-1:1]};
      end
      return r;
   endfunction

   function automatic logic [B-1:0] true_bits(input int w);
      logic [B-1:0] r;
      for (int j = 0; j < B; j++) r[j] = u_hist[w*B + j];
      return r;
   endfunction

   task automatic run_phase(input int nwin);
      logic [SB-1:0] ts, prev;
      logic          u;
      int            mode;
      ts = '0;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      c = 0;
      // R7 reset state
      check("R7 bit_valid after reset", int'(bit_valid), 0);
      check("R7 bit_line after reset", int'(bit_line), 0);
      check("R1 restart after reset", int'(restart), 0);
      for (int n = 0; n < nwin*B; n++) begin
         u = 1'($urandom_range(0, 1));
         prev = ts;
         ts = {ts[SB-2:0], u};
         u_hist[n] = u;
         dec_hist[n] = NS'($urandom);
         dec_hist[n][ts] = prev[SB-1];
         mode = (n / B) % 4;
         for (int s = 0; s < NS; s++) met[n][s] = $urandom_range(0, 12);
         if (n % B == B - 1) begin
            case (mode)
               0: met[n][ts] = 15;
               1: for (int s = 0; s < NS; s++) met[n][s] = 0;
               2: begin
                  for (int s = 0; s < NS; s++) met[n][s] = $urandom_range(0, 8);
                  met[n][3] = 9; met[n][1] = 9;
               end
               default: ;
            endcase
         end
         dec_vec = dec_hist[n];
         for (int s = 0; s < NS; s++) path_metrics[s*MW +: MW] = MW'(met[n][s]);
         @(posedge clk);
         c++;
         @(negedge clk);
         // R1 restart timing
         check("R1 restart", int'(restart), int'(c % B == B - 1));
         // R2/R3 strobe timing
         check("R3 bit_valid timing", int'(bit_valid),
               int'(c >= 3*B && c % B == 0));
         if (c >= 3*B && c % B == 0) begin
            int w;
            w = c / B - 2;
            // R4 R5 R6 decoded window
            check("R6 bit_line vs traceback", int'(bit_line), int'(model(w)));
            if (w % 4 == 0)
               check("R5 bit_line vs source bits", int'(bit_line), int'(true_bits(w)));
            if (w % 4 == 1)
               check("R4 all-zero metrics start at state 0", int'(bit_line), int'(model(w)));
         end
      end
   endtask

   initial begin
      run_phase(14);
      run_phase(9);   // second reset: R7 warm-up restarts
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule